// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block holds the single write-only banking register of a game console cartridge and turns CPU and video addresses into physical memory addresses. A CPU write that lands in the switchable program window stores one byte. That byte carries a program bank number and a pattern-RAM bank number. Everything else is combinational. The CPU address becomes a program ROM address, built from a switchable lower 16 KiB window and an upper window fixed to the last bank. The video address becomes a pattern-RAM address, built from a lower 4 KiB window fixed to bank 0 and a switchable upper 4 KiB window.

Pattern RAM read and write enables are gated so that only video accesses inside the pattern space (below $2000) reach the RAM. The nametable mirroring output is a fixed tie-off to vertical. The ROM and RAM arrays sit outside this block.

Top module: `cart_bank_xlate`

## Requirements
- R1: A CPU write with `cpu_wr`=1 to any address in $8000–$BFFF updates the register at that clock edge. `cpu_data[7:6]` becomes the program bank and `cpu_data[3:0]` becomes the pattern bank.
- R2: Bits 5:4 of the written byte have no effect on either bank.
- R3: CPU writes to $C000–$FFFF, or to any address below $8000, leave both banks unchanged.
- R4: For CPU addresses $8000–$BFFF, `prg_addr` = {program bank, `cpu_addr[13:0]`}.
- R5: For CPU addresses $C000–$FFFF, `prg_addr` = {2'b11, `cpu_addr[13:0]`}, whatever the register holds.
- R6: For video addresses $0000–$0FFF, `pat_addr` = {4'h0, `vid_addr[11:0]`}, whatever the register holds.
- R7: For video addresses $1000–$1FFF, `pat_addr` = {pattern bank, `vid_addr[11:0]`}, covering banks 0 to 15.
- R8: `pat_rd_en` = `vid_rd` and `pat_wr_en` = `vid_wr` while `vid_addr` < $2000; both are 0 otherwise.
- R9: `mirror_vert` is always 1, meaning vertical mirroring.
- R10: While `rst_n` is low, and after reset until the first R1 write, both banks read as 0.
- R11: Address translation has no latency. `prg_addr` and `pat_addr` follow an address change in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one per clock |
| vid_addr | input | 14 | Video address |
| vid_rd | input | 1 | Video read request |
| vid_wr | input | 1 | Video write request |
| prg_addr | output | 16 | Program ROM byte address |
| pat_addr | output | 16 | Pattern RAM byte address |
| pat_rd_en | output | 1 | Pattern RAM read enable |
| pat_wr_en | output | 1 | Pattern RAM write enable |
| mirror_vert | output | 1 | Nametable mirroring, 1 = vertical |

## Verification
A wrong bank register value shows up the first time the CPU touches $8000–$BFFF or the video side touches $1000–$1FFF. The error is visible in the upper bits of `prg_addr` or `pat_addr` in that same cycle. A decode that accepts writes in the fixed window corrupts the bank the cycle after that write, and the bench's per-clock comparison against its own model of the register catches it there. Errors in the fixed windows need no prior write to show: any address in $C000–$FFFF or $0000–$0FFF exposes them at once.

// File: rtl/cart_xlate_pkg.sv
package cart_xlate_pkg;

   typedef enum logic [1:0] {
      RGN_NONE   = 2'd0,
      RGN_SWITCH = 2'd1,
      RGN_FIXED  = 2'd2
   } cpu_rgn_e;

   // Top two CPU address bits: 10 = switchable window, 11 = fixed window
   function automatic cpu_rgn_e decode_rgn(input logic [1:0] top_bits);
      case (top_bits)
         2'b10:   decode_rgn = RGN_SWITCH;
         2'b11:   decode_rgn = RGN_FIXED;
         default: decode_rgn = RGN_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 2,
   parameter int PAT_BANK_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [DATA_W-1:0]     wdata,
   output logic [PRG_BANK_W-1:0] prg_bank,
   output logic [PAT_BANK_W-1:0] pat_bank
);

   localparam int PRG_LSB = DATA_W - PRG_BANK_W;

   generate
      if (PRG_BANK_W + PAT_BANK_W > DATA_W) begin : g_bad_split
         $error("bank fields overlap inside the data byte");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prg_bank <= '0;
         pat_bank <= '0;
      end else if (load) begin
         prg_bank <= wdata[DATA_W-1:PRG_LSB];
         pat_bank <= wdata[PAT_BANK_W-1:0];
      end
   end

endmodule

// File: rtl/cart_prg_xlate.sv
module cart_prg_xlate #(
   parameter int PRG_BANK_W    = 2,
   parameter int PRG_WIN_W     = 14,
   parameter bit FIX_UPPER_LAST = 1'b1
) (
   input  logic                           upper_win,
   input  logic [PRG_WIN_W-1:0]           win_offset,
   input  logic [PRG_BANK_W-1:0]          sel_bank,
   output logic [PRG_BANK_W+PRG_WIN_W-1:0] rom_addr
);

   localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

   logic [PRG_BANK_W-1:0] eff_bank;

   generate
      if (FIX_UPPER_LAST) begin : g_fixed_upper
         assign eff_bank = upper_win ? LAST_BANK : sel_bank;
      end else begin : g_flat
         assign eff_bank = sel_bank;
      end
   endgenerate

   assign rom_addr = {eff_bank, win_offset};

endmodule

// File: rtl/cart_pat_xlate.sv
module cart_pat_xlate #(
   parameter int VID_AW     = 14,
   parameter int PAT_BANK_W = 4,
   parameter int PAT_WIN_W  = 12
) (
   input  logic [VID_AW-1:0]               vid_addr,
   input  logic                            vid_rd,
   input  logic                            vid_wr,
   input  logic [PAT_BANK_W-1:0]           sel_bank,
   output logic [PAT_BANK_W+PAT_WIN_W-1:0] ram_addr,
   output logic                            rd_en,
   output logic                            wr_en
);

   // Pattern space is two windows: addresses below 2 * 2**PAT_WIN_W
   localparam int SPACE_MSB = PAT_WIN_W + 1;

   generate
      if (VID_AW <= SPACE_MSB) begin : g_bad_width
         $error("video address too narrow for two pattern windows");
      end
   endgenerate

   logic                  in_space;
   logic                  upper_win;
   logic [PAT_BANK_W-1:0] eff_bank;

   assign in_space  = (vid_addr[VID_AW-1:SPACE_MSB] == '0);
   assign upper_win = vid_addr[PAT_WIN_W];
   assign eff_bank  = upper_win ? sel_bank : '0;
   assign ram_addr  = {eff_bank, vid_addr[PAT_WIN_W-1:0]};
   assign rd_en     = vid_rd & in_space;
   assign wr_en     = vid_wr & in_space;

endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
   import cart_xlate_pkg::*;
#(
   parameter int CPU_AW      = 16,
   parameter int VID_AW      = 14,
   parameter int DATA_W      = 8,
   parameter int PRG_BANK_W  = 2,
   parameter int PAT_BANK_W  = 4,
   parameter int PRG_WIN_W   = 14,
   parameter int PAT_WIN_W   = 12,
   parameter bit MIRROR_VERT = 1'b1,
   localparam int PRG_AW     = PRG_BANK_W + PRG_WIN_W,
   localparam int PAT_AW     = PAT_BANK_W + PAT_WIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_wr,
   input  logic [VID_AW-1:0] vid_addr,
   input  logic              vid_rd,
   input  logic              vid_wr,
   output logic [PRG_AW-1:0] prg_addr,
   output logic [PAT_AW-1:0] pat_addr,
   output logic              pat_rd_en,
   output logic              pat_wr_en,
   output logic              mirror_vert
);

   generate
      if (CPU_AW != PRG_WIN_W + 2) begin : g_bad_cpu
         $error("CPU space must be four program windows");
      end
   endgenerate

   cpu_rgn_e              rgn;
   logic                  reg_load;
   logic [PRG_BANK_W-1:0] prg_bank_q;
   logic [PAT_BANK_W-1:0] pat_bank_q;

   assign rgn      = decode_rgn(cpu_addr[CPU_AW-1:CPU_AW-2]);
   assign reg_load = cpu_wr && (rgn == RGN_SWITCH);

   cart_bank_reg #(
      .DATA_W    (DATA_W),
      .PRG_BANK_W(PRG_BANK_W),
      .PAT_BANK_W(PAT_BANK_W)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (reg_load),
      .wdata   (cpu_data),
      .prg_bank(prg_bank_q),
      .pat_bank(pat_bank_q)
   );

   cart_prg_xlate #(
      .PRG_BANK_W    (PRG_BANK_W),
      .PRG_WIN_W     (PRG_WIN_W),
      .FIX_UPPER_LAST(1'b1)
   ) u_prg (
      .upper_win (rgn == RGN_FIXED),
      .win_offset(cpu_addr[PRG_WIN_W-1:0]),
      .sel_bank  (prg_bank_q),
      .rom_addr  (prg_addr)
   );

   cart_pat_xlate #(
      .VID_AW    (VID_AW),
      .PAT_BANK_W(PAT_BANK_W),
      .PAT_WIN_W (PAT_WIN_W)
   ) u_pat (
      .vid_addr(vid_addr),
      .vid_rd  (vid_rd),
      .vid_wr  (vid_wr),
      .sel_bank(pat_bank_q),
      .ram_addr(pat_addr),
      .rd_en   (pat_rd_en),
      .wr_en   (pat_wr_en)
   );

   generate
      if (MIRROR_VERT) begin : g_mirror_v
         assign mirror_vert = 1'b1;
      end else begin : g_mirror_h
         assign mirror_vert = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cart_bank_xlate_chk.sv
module cart_bank_xlate_chk #(
   parameter int CPU_AW     = 16,
   parameter int VID_AW     = 14,
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 2,
   parameter int PAT_BANK_W = 4,
   parameter int PRG_WIN_W  = 14,
   parameter int PAT_WIN_W  = 12
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [CPU_AW-1:0]               cpu_addr,
   input logic [DATA_W-1:0]               cpu_data,
   input logic                            cpu_wr,
   input logic [VID_AW-1:0]               vid_addr,
   input logic                            vid_wr,
   input logic [PRG_BANK_W-1:0]           prg_bank,
   input logic [PAT_BANK_W-1:0]           pat_bank,
   input logic [PRG_BANK_W+PRG_WIN_W-1:0] prg_addr,
   input logic [PAT_BANK_W+PAT_WIN_W-1:0] pat_addr,
   input logic                            pat_wr_en
);

   localparam int PRG_AW = PRG_BANK_W + PRG_WIN_W;
   localparam int PAT_AW = PAT_BANK_W + PAT_WIN_W;

   logic in_switch, in_fixed, low_pat, high_pat;
   assign in_switch = (cpu_addr[CPU_AW-1:CPU_AW-2] == 2'b10);
   assign in_fixed  = (cpu_addr[CPU_AW-1:CPU_AW-2] == 2'b11);
   assign low_pat   = (vid_addr[VID_AW-1:PAT_WIN_W] == '0);
   assign high_pat  = (vid_addr[VID_AW-1:PAT_WIN_W] == 1);

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && in_switch) |=>
         (prg_bank == $past(cpu_data[DATA_W-1:DATA_W-PRG_BANK_W])) &&
         (pat_bank == $past(cpu_data[PAT_BANK_W-1:0])));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && in_switch) |=> ($stable(prg_bank) && $stable(pat_bank)));

   p_switch_prg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_switch |-> (prg_addr[PRG_AW-1:PRG_WIN_W] == prg_bank));

   p_fixed_prg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_fixed |-> ((&prg_addr[PRG_AW-1:PRG_WIN_W]) &&
                    (prg_addr[PRG_WIN_W-1:0] == cpu_addr[PRG_WIN_W-1:0])));

   p_low_pat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      low_pat |-> (pat_addr[PAT_AW-1:PAT_WIN_W] == '0));

   p_high_pat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      high_pat |-> (pat_addr[PAT_AW-1:PAT_WIN_W] == pat_bank));

   p_wr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pat_wr_en |-> (vid_wr && (low_pat || high_pat)));

endmodule

bind cart_bank_xlate cart_bank_xlate_chk #(
   .CPU_AW    (CPU_AW),
   .VID_AW    (VID_AW),
   .DATA_W    (DATA_W),
   .PRG_BANK_W(PRG_BANK_W),
   .PAT_BANK_W(PAT_BANK_W),
   .PRG_WIN_W (PRG_WIN_W),
   .PAT_WIN_W (PAT_WIN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .cpu_data (cpu_data),
   .cpu_wr   (cpu_wr),
   .vid_addr (vid_addr),
   .vid_wr   (vid_wr),
   .prg_bank (prg_bank_q),
   .pat_bank (pat_bank_q),
   .prg_addr (prg_addr),
   .pat_addr (pat_addr),
   .pat_wr_en(pat_wr_en)
);

// File: tb/cart_bank_xlate_tb.sv
module cart_bank_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic [13:0] vid_addr = '0;
   logic        vid_rd = 1'b0;
   logic        vid_wr = 1'b0;
   logic [15:0] prg_addr;
   logic [15:0] pat_addr;
   logic        pat_rd_en;
   logic        pat_wr_en;
   logic        mirror_vert;

   int total = 0;
   int bad   = 0;
   int ref_prg = 0;
   int ref_pat = 0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   cart_bank_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .vid_addr(vid_addr), .vid_rd(vid_rd), .vid_wr(vid_wr),
      .prg_addr(prg_addr), .pat_addr(pat_addr), .pat_rd_en(pat_rd_en),
      .pat_wr_en(pat_wr_en), .mirror_vert(mirror_vert)
   );

   // Behavioural model of the bank register
   always @(posedge clk) begin
      if (!rst_n) begin
         ref_prg = 0;
         ref_pat = 0;
      end else if (cpu_wr && cpu_addr >= 16'h8000 && cpu_addr < 16'hC000) begin
         ref_prg = int'(cpu_data) / 64;
         ref_pat = int'(cpu_data) % 16;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int off;
      if (cpu_addr >= 16'hC000)
         chk("R5 fixed prg", int'(prg_addr), 49152 + int'(cpu_addr) % 16384);
      else if (cpu_addr >= 16'h8000)
         chk("R4 switch prg", int'(prg_addr), ref_prg * 16384 + int'(cpu_addr) % 16384);
      off = int'(vid_addr) % 4096;
      if (vid_addr < 14'h1000)
         chk("R6 low pat", int'(pat_addr), off);
      else if (vid_addr < 14'h2000)
         chk("R7 high pat", int'(pat_addr), ref_pat * 4096 + off);
      chk("R8 rd_en", int'(pat_rd_en), int'(vid_rd && vid_addr < 14'h2000));
      chk("R8 wr_en", int'(pat_wr_en), int'(vid_wr && vid_addr < 14'h2000));
      chk("R9 mirror", int'(mirror_vert), 1);
   endtask

   always @(negedge clk) begin
      #2;
      if (cmp_on) compare_all();
   end

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a;
      cpu_data = d;
      cpu_wr   = 1'b1;
      @(negedge clk);
      cpu_wr   = 1'b0;
   endtask

   task automatic look(input logic [15:0] ca, input logic [13:0] va);
      cpu_addr = ca;
      vid_addr = va;
      #1;
   endtask

   initial begin : watchdog
      #(100000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: banks read 0 during reset, write ignored under reset
      cpu_addr = 16'h8000; cpu_data = 8'hFF; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      look(16'h8123, 14'h1ABC);
      chk("R10 reset prg", int'(prg_addr), 16'h0123);
      chk("R10 reset pat", int'(pat_addr), 16'h0ABC);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      look(16'hA000, 14'h1FFF);
      chk("R10 after reset prg", int'(prg_addr), 16'h2000);
      chk("R10 after reset pat", int'(pat_addr), 16'h0FFF);
      cmp_on = 1'b1;

      // R1: load banks 3 and 5
      cpu_write(16'h8000, 8'hC5);
      look(16'h8123, 14'h1ABC);
      chk("R1 prg bank", int'(prg_addr), 16'hC123);
      chk("R1 pat bank", int'(pat_addr), 16'h5ABC);
      // R1 at top of window, R2: bits 5:4 set
      cpu_write(16'hBFFF, 8'h7A);
      look(16'h9000, 14'h1001);
      chk("R1 top addr prg", int'(prg_addr), 16'h5000);
      chk("R2 pat ignores 5:4", int'(pat_addr), 16'hA001);
      cpu_write(16'h8800, 8'h30);
      look(16'h8000, 14'h1000);
      chk("R2 prg zero", int'(prg_addr), 16'h0000);
      chk("R2 pat zero", int'(pat_addr), 16'h0000);

      // R3: writes outside window
      cpu_write(16'h8000, 8'h4F);
      cpu_write(16'hC000, 8'hB0);
      cpu_write(16'hFFFF, 8'h82);
      cpu_write(16'h7FFF, 8'hC3);
      cpu_write(16'h0000, 8'h81);
      look(16'h8000, 14'h1000);
      chk("R3 prg kept", int'(prg_addr), 16'h4000);
      chk("R3 pat kept", int'(pat_addr), 16'hF000);

      // R5/R6 fixed windows regardless of register
      look(16'hC000, 14'h0000);
      chk("R5 fixed start", int'(prg_addr), 16'hC000);
      chk("R6 low start", int'(pat_addr), 16'h0000);
      look(16'hFFFF, 14'h0FFF);
      chk("R5 fixed end", int'(prg_addr), 16'hFFFF);
      chk("R6 low end", int'(pat_addr), 16'h0FFF);

      // R11: no latency, change address between edges
      look(16'h8001, 14'h1002);
      chk("R11 prg immediate", int'(prg_addr), 16'h4001);
      look(16'hE001, 14'h0002);
      chk("R11 prg fixed immediate", int'(prg_addr), 16'hE001);
      chk("R11 pat immediate", int'(pat_addr), 16'h0002);

      // R8: enable gating
      vid_rd = 1'b1; vid_wr = 1'b1;
      look(16'h8000, 14'h2000);
      chk("R8 rd off above", int'(pat_rd_en), 0);
      chk("R8 wr off above", int'(pat_wr_en), 0);
      look(16'h8000, 14'h1FFF);
      chk("R8 rd on", int'(pat_rd_en), 1);
      chk("R8 wr on", int'(pat_wr_en), 1);
      vid_rd = 1'b0; vid_wr = 1'b0;

      // Randomized traffic, model compared every clock
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         cpu_addr = 16'($urandom);
         cpu_data = 8'($urandom);
         cpu_wr   = ($urandom % 3) == 0;
         vid_addr = 14'($urandom);
         vid_rd   = 1'($urandom);
         vid_wr   = 1'($urandom);
      end
      @(negedge clk);
      cpu_wr = 1'b0;

      // R10: reset mid-run returns banks to 0
      cpu_write(16'h9000, 8'hFF);
      cmp_on = 1'b0;
      rst_n  = 1'b0;
      @(negedge clk);
      look(16'h8000, 14'h1000);
      chk("R10 rereset prg", int'(prg_addr), 16'h0000);
      chk("R10 rereset pat", int'(pat_addr), 16'h0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule